// File: doc/BRIEF.md
# Partial Address Overlap Matrix

This block looks at a small window of in-flight memory operations, four loads and four stores, and reports for every pair of them whether the two accesses might touch the same bytes. The scheduler uses the report to find operations that can safely be issued side by side. A report of "no overlap" must be trustworthy. A report of "overlap" may be pessimistic. Keeping memory operations in the right order is done elsewhere. The block only finds chances for parallel issue.

The block does not compare the full 64-bit addresses. Each slot is reduced to a key with three parts:
- **Middle field:** address bits 11:4, compared exactly.
- **Byte-lane mask:** 16 bits, built from the access size shifted by the offset in address bits 3:0.
- **Folded hash:** 4 bits, made by XOR-folding address bits 22:12.

Two keys conflict only when the middle fields are equal, the lane masks intersect and the hashes are equal. An access that runs past the end of its 16-byte line cannot be described by one mask, so it is treated as conflicting with every other valid slot. The whole matrix is combinational and is re-evaluated every cycle.

The block has no states. It is pure combinational logic with no clock or reset. The slots have a fixed order: loads take indices 0 to 3 and stores take indices 4 to 7.

Top module: `addr_overlap_matrix`

## Requirements
- R1: Slot index i is load i for i < 4 and store i-4 for i >= 4. The entry for pair (i,j) is bit i*8+j of `overlap_o`.
- R2: The size code selects the access width: code 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes. The access covers bytes addr through addr+width-1.
- R3: If either slot of a pair is invalid, the entry is 0 in both the row and the column.
- R4: Every diagonal entry (i,i) is 0.
- R5: Entry (i,j) always equals entry (j,i).
- R6: If neither access crosses a 16-byte line and address bits 11:4 differ, the entry is 0.
- R7: If neither access crosses a line and the byte ranges within the line are disjoint (offset = bits 3:0, misaligned accesses included), the entry is 0.
- R8: The hash bit k is the XOR of address bits 12+k, 16+k and 20+k, for those bits that lie at or below bit 22. If neither access crosses a line and the hashes differ, the entry is 0.
- R9: An access with offset + width > 16 conflicts with every other valid slot.
- R10: Any two valid slots whose byte ranges truly overlap are reported as overlapping.
- R11: Two accesses whose addresses differ only by 1 MiB are reported as not overlapping.
- R12: In all other cases (both valid, no line crossing, equal middle fields, intersecting masks, equal hashes) the entry is 1. The matrix follows the inputs with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_valid_i | input | 4 | Load slot valid bits |
| ld_addr_i | input | 256 | Load addresses, 64 bits per slot, slot 0 lowest |
| ld_size_i | input | 8 | Load size codes, 2 bits per slot |
| st_valid_i | input | 4 | Store slot valid bits |
| st_addr_i | input | 256 | Store addresses, 64 bits per slot |
| st_size_i | input | 8 | Store size codes, 2 bits per slot |
| overlap_o | output | 64 | Pairwise may-overlap matrix, bit i*8+j |

## Verification
The bench builds the block with its default parameters: four load slots, four store slots and 64-bit addresses.

It sweeps every offset and size of one pair against every offset and size of the other. This is done for a load/store pair, a load/load pair and a store/store pair, which covers every misaligned and line-crossing combination.

It also steps a single-bit address difference through bits 4 to 30. This shows where the middle field, the hash and the aliasing beyond bit 22 each take effect. The bench then sweeps all 256 valid patterns, and finally runs clustered pseudo-random windows in which every pair is checked against a true byte-range overlap model.

// File: rtl/aom_pkg.sv
package aom_pkg;
    localparam int SIZE_W  = 2;
    localparam int OFF_W   = 4;
    localparam int LANES   = 1 << OFF_W;
    localparam int MID_LO  = OFF_W;
    localparam int MID_HI  = 11;
    localparam int HASH_LO = MID_HI + 1;
    localparam int HASH_HI = 22;
    localparam int HASH_W  = 4;
    localparam int MAXB    = 8;

    typedef logic [SIZE_W-1:0]        size_t;
    typedef logic [LANES-1:0]         lane_t;
    typedef logic [HASH_W-1:0]        hash_t;
    typedef logic [MID_HI-MID_LO:0]   mid_t;

    typedef struct packed {
        logic  valid;
        logic  spill;
        mid_t  mid;
        hash_t hash;
        lane_t lanes;
    } slot_key_t;
endpackage

// File: rtl/aom_lane_mask.sv
module aom_lane_mask
    import aom_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    input  size_t            size_i,
    output lane_t            lanes_o,
    output logic             spill_o
);
    localparam int WIDE_W = 2 * LANES;

    logic [MAXB-1:0]   pat;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        unique case (size_i)
            2'd0:    pat = 8'h01;
            2'd1:    pat = 8'h03;
            2'd2:    pat = 8'h0F;
            default: pat = 8'hFF;
        endcase
        wide    = WIDE_W'(pat) << off_i;
        lanes_o = wide[LANES-1:0];
        spill_o = |wide[WIDE_W-1:LANES];
    end

    // The shifted pattern holds exactly the access width in bytes (R2)
    always_comb begin
        p_lane_count_r2: assert ($countones(wide) == (1 << size_i))
            else $error("lane pattern width mismatch");
    end
endmodule

// File: rtl/aom_hash_fold.sv
module aom_hash_fold
    import aom_pkg::*;
(
    input  logic [HASH_HI:HASH_LO] bits_i,
    output hash_t                  hash_o
);
    always_comb begin
        hash_o = '0;
        for (int b = HASH_LO; b <= HASH_HI; b++) begin
            hash_o[(b - HASH_LO) % HASH_W] ^= bits_i[b];
        end
    end
endmodule

// File: rtl/aom_slot_key.sv
module aom_slot_key
    import aom_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  size_t             size_i,
    output slot_key_t         key_o
);
    lane_t lanes;
    logic  spill;
    hash_t hash;
    logic  unused_high;

    aom_lane_mask u_mask (
        .off_i   (addr_i[OFF_W-1:0]),
        .size_i  (size_i),
        .lanes_o (lanes),
        .spill_o (spill)
    );

    aom_hash_fold u_hash (
        .bits_i (addr_i[HASH_HI:HASH_LO]),
        .hash_o (hash)
    );

    assign unused_high = ^addr_i[ADDR_W-1:HASH_HI+1];

    always_comb begin
        key_o.valid = valid_i;
        key_o.spill = spill;
        key_o.mid   = addr_i[MID_HI:MID_LO];
        key_o.hash  = hash;
        key_o.lanes = lanes;
    end
endmodule

// File: rtl/aom_pair_cmp.sv
module aom_pair_cmp
    import aom_pkg::*;
(
    input  slot_key_t a_i,
    input  slot_key_t b_i,
    output logic      hit_o
);
    logic mid_eq, lane_hit, hash_eq;

    always_comb begin
        mid_eq   = (a_i.mid == b_i.mid);
        lane_hit = |(a_i.lanes & b_i.lanes);
        hash_eq  = (a_i.hash == b_i.hash);
        hit_o    = a_i.valid & b_i.valid &
                   (a_i.spill | b_i.spill | (mid_eq & lane_hit & hash_eq));
    end
endmodule

// File: rtl/addr_overlap_matrix.sv
module addr_overlap_matrix
    import aom_pkg::*;
#(
    parameter int NUM_LD = 4,
    parameter int NUM_ST = 4,
    parameter int ADDR_W = 64
) (
    input  logic [NUM_LD-1:0]        ld_valid_i,
    input  logic [NUM_LD*ADDR_W-1:0] ld_addr_i,
    input  logic [NUM_LD*SIZE_W-1:0] ld_size_i,
    input  logic [NUM_ST-1:0]        st_valid_i,
    input  logic [NUM_ST*ADDR_W-1:0] st_addr_i,
    input  logic [NUM_ST*SIZE_W-1:0] st_size_i,
    output logic [(NUM_LD+NUM_ST)*(NUM_LD+NUM_ST)-1:0] overlap_o
);
    localparam int NSLOT = NUM_LD + NUM_ST;

    slot_key_t key [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s < NUM_LD) begin : g_ld
            aom_slot_key #(.ADDR_W(ADDR_W)) u_key (
                .valid_i (ld_valid_i[s]),
                .addr_i  (ld_addr_i[s*ADDR_W +: ADDR_W]),
                .size_i  (ld_size_i[s*SIZE_W +: SIZE_W]),
                .key_o   (key[s])
            );
        end else begin : g_st
            aom_slot_key #(.ADDR_W(ADDR_W)) u_key (
                .valid_i (st_valid_i[s-NUM_LD]),
                .addr_i  (st_addr_i[(s-NUM_LD)*ADDR_W +: ADDR_W]),
                .size_i  (st_size_i[(s-NUM_LD)*SIZE_W +: SIZE_W]),
                .key_o   (key[s])
            );
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_row
        for (genvar j = 0; j < NSLOT; j++) begin : g_col
            if (i == j) begin : g_diag
                assign overlap_o[i*NSLOT+j] = 1'b0;
            end else if (j > i) begin : g_upper
                logic hit;
                aom_pair_cmp u_cmp (
                    .a_i   (key[i]),
                    .b_i   (key[j]),
                    .hit_o (hit)
                );
                assign overlap_o[i*NSLOT+j] = hit;
                assign overlap_o[j*NSLOT+i] = hit;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            for (int j = 0; j < NSLOT; j++) begin
                if (i != j) begin
                    if (!key[i].valid) begin
                        p_invalid_quiet_r3: assert (!overlap_o[i*NSLOT+j])
                            else $error("invalid slot reported");
                    end
                    if (key[i].valid && key[j].valid && key[i].spill) begin
                        p_spill_conflict_r9: assert (overlap_o[i*NSLOT+j])
                            else $error("line-crossing slot not flagged");
                    end
                    if (overlap_o[i*NSLOT+j] && !key[i].spill && !key[j].spill) begin
                        p_mid_equal_r6: assert (key[i].mid == key[j].mid)
                            else $error("overlap with differing middle field");
                        p_hash_equal_r8: assert (key[i].hash == key[j].hash)
                            else $error("overlap with differing hash");
                        p_lanes_meet_r7: assert (|(key[i].lanes & key[j].lanes))
                            else $error("overlap with disjoint lanes");
                    end
                end
            end
        end
    end
endmodule

// File: tb/addr_overlap_matrix_bench.sv
module addr_overlap_matrix_bench;
    localparam int N  = 8;
    localparam int AW = 64;

    logic clk = 1'b0;
    always #2.5ns clk = ~clk;

    logic                 va [N];
    logic [AW-1:0]        aa [N];
    logic [1:0]           sa [N];

    logic [3:0]    ld_valid, st_valid;
    logic [4*AW-1:0] ld_addr, st_addr;
    logic [7:0]    ld_size, st_size;
    logic [N*N-1:0] ovl;

    int checks = 0;
    int errors = 0;
    int false_pos = 0;
    bit done = 0;

    always_comb begin
        for (int s = 0; s < 4; s++) begin
            ld_valid[s]          = va[s];
            ld_addr[s*AW +: AW]  = aa[s];
            ld_size[s*2 +: 2]    = sa[s];
            st_valid[s]          = va[s+4];
            st_addr[s*AW +: AW]  = aa[s+4];
            st_size[s*2 +: 2]    = sa[s+4];
        end
    end

    addr_overlap_matrix u_addr_overlap_matrix (
        .ld_valid_i (ld_valid),
        .ld_addr_i  (ld_addr),
        .ld_size_i  (ld_size),
        .st_valid_i (st_valid),
        .st_addr_i  (st_addr),
        .st_size_i  (st_size),
        .overlap_o  (ovl)
    );

    function automatic logic [3:0] fold(logic [AW-1:0] a);
        logic [3:0] h = '0;
        for (int k = 0; k < 4; k++)
            for (int b = 12 + k; b <= 22; b += 4) h[k] ^= a[b];
        return h;
    endfunction

    function automatic logic exp_pair(int i, int j);
        int oi, oj, bi, bj, lo, hi;
        if (i == j || !va[i] || !va[j]) return 1'b0;
        oi = int'(aa[i][3:0]); oj = int'(aa[j][3:0]);
        bi = 1 << sa[i];       bj = 1 << sa[j];
        if (oi + bi > 16 || oj + bj > 16) return 1'b1;
        if (aa[i][11:4] != aa[j][11:4]) return 1'b0;
        if (fold(aa[i]) != fold(aa[j])) return 1'b0;
        lo = (oi > oj) ? oi : oj;
        hi = (oi + bi < oj + bj) ? oi + bi : oj + bj;
        return lo < hi;
    endfunction

    function automatic logic true_pair(int i, int j);
        longint unsigned ai, aj;
        if (i == j || !va[i] || !va[j]) return 1'b0;
        ai = aa[i]; aj = aa[j];
        return (ai < aj + (1 << sa[j])) && (aj < ai + (1 << sa[i]));
    endfunction

    task automatic check_now(string tag);
        logic [N*N-1:0] exp_m;
        logic [N*N-1:0] miss;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                exp_m[i*N+j] = exp_pair(i, j);
                miss[i*N+j]  = true_pair(i, j) & ~ovl[i*N+j];
                if (ovl[i*N+j] && !true_pair(i, j)) false_pos++;
            end
        checks++;
        if (ovl !== exp_m) begin
            errors++;
            $display("FAIL %s matrix actual %h expected %h", tag, ovl, exp_m);
        end
        checks++;
        if (miss != '0) begin
            errors++;
            $display("FAIL R10 missed overlap actual %h expected 0 (%s)", miss, tag);
        end
    endtask

    task automatic clear_all();
        for (int s = 0; s < N; s++) begin
            va[s] = 1'b0; aa[s] = '0; sa[s] = 2'd0;
        end
    endtask

    task automatic apply(string tag);
        @(negedge clk);
        check_now(tag);
        @(posedge clk);
    endtask

    task automatic pair_sweep(int p, int q, string tag);
        logic [AW-1:0] base = 64'h0000_0042_3A5C_7100;
        for (int o1 = 0; o1 < 16; o1++)
            for (int s1 = 0; s1 < 4; s1++)
                for (int o2 = 0; o2 < 16; o2++)
                    for (int s2 = 0; s2 < 4; s2++) begin
                        clear_all();
                        va[p] = 1'b1; aa[p] = base + AW'(o1); sa[p] = 2'(s1);
                        va[q] = 1'b1; aa[q] = base + AW'(o2); sa[q] = 2'(s2);
                        apply(tag);
                    end
    endtask

    initial begin
        #(100000 * 5ns);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        clear_all();
        @(posedge clk);
        // R3 / R12: nothing valid means an all-zero matrix
        apply("R3 idle");

        // R1 R2 R7 R9 R12: exhaustive offset/size, load-store pair
        pair_sweep(0, 4, "R7 R9 R1 ld-st");
        // R4 R5: load-load and store-store pairs
        pair_sweep(1, 2, "R5 R2 ld-ld");
        pair_sweep(5, 7, "R4 R12 st-st");

        // R6 R8 R11: single-bit address strides
        for (int k = 4; k <= 30; k++) begin
            clear_all();
            va[3] = 1'b1; aa[3] = 64'h0000_0010_0000_0000; sa[3] = 2'd3;
            va[6] = 1'b1; aa[6] = aa[3] + (64'd1 << k); sa[6] = 2'd3;
            if (k == 20) begin
                apply("R11 1MiB stride");
                checks++;
                if (ovl[3*N+6] !== 1'b0) begin
                    errors++;
                    $display("FAIL R11 actual %b expected 0", ovl[3*N+6]);
                end
            end else if (k <= 11) apply("R6 mid stride");
            else apply("R8 hash stride");
        end

        // R3: every valid pattern with identical accesses
        for (int m = 0; m < 256; m++) begin
            for (int s = 0; s < N; s++) begin
                va[s] = m[s]; aa[s] = 64'h0000_0000_0080_1238; sa[s] = 2'd2;
            end
            apply("R3 valid gating");
        end

        // R10 R5 R4: clustered pseudo-random windows
        lfsr = 32'hACE1_2468;
        for (int t = 0; t < 2000; t++) begin
            for (int s = 0; s < N; s++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                va[s] = lfsr[0] | lfsr[1];
                sa[s] = lfsr[3:2];
                aa[s] = 64'h0000_0007_0000_0000 + AW'(lfsr[9:4])
                      + (lfsr[10] ? (AW'(lfsr[20:11]) << 12) : '0);
            end
            apply("R10 random window");
        end

        $display("false positives counted: %0d", false_pos);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule